// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block manages self refresh for one DRAM channel and sits next to that channel's command scheduler. While the scheduler owns the command bus, an idle counter watches the controller. The counter runs only while the controller reports that it is drained and no new request arrives. When the count reaches a programmed threshold, the block takes over the bus and puts every populated rank into self refresh. A power-control agent can also order entry directly. Either of two causes brings the channel out again: an explicit wake message, or a transaction arriving at the controller.

Leaving self refresh follows a fixed order:

1. The DRAM clock is restarted and runs for four cycles.
2. A programmable settling delay passes with clock-enable still low.
3. Clock-enable rises and a NOP window of programmable length follows.
4. A long ZQ calibration is issued to each rank in ascending rank order. Consecutive calibrations are separated by a programmable gap.
5. The scheduler is re-enabled.

While the channel is outside normal operation, the scheduler is disabled and incoming transactions are back-pressured. A master-DLL shutdown request can be raised, if configured, but only while the ranks are in self refresh. Exit waits for the PLL ready indication.

Top module: `dram_sref_seq`

## Requirements
- R1: After reset the block is in normal operation. `sched_en_o`=1, `txn_stall_o`=0, `dram_ck_en_o`=1, `dram_cke_o`=mask of populated ranks, `dram_cmd_o`=0 (scheduler owns the bus), `dram_rank_sel_o`=0 and `dll_off_req_o`=0.
- R2: With `cfg_auto_en_i`=1, entry starts after N consecutive cycles in which `mc_drained_i`=1 and `mc_req_i`=0. N is `cfg_idle_thresh_i`, and a threshold of 0 acts as 1. Any cycle with a request or without drained restarts the count from zero.
- R3: With `cfg_auto_en_i`=0 no idle-triggered entry happens. A one-cycle `pwr_enter_req_i` starts entry at the next edge if the controller is drained and has no request, and is ignored otherwise.
- R4: Entry issues exactly one cycle of command code 2 (self-refresh entry) with all populated ranks selected, clock-enable low and the clock running. The following self-refresh state has the clock stopped, clock-enable low and command code 1 (NOP).
- R5: In self refresh, `pwr_exit_req_i`=1 or `mc_req_i`=1 starts the exit sequence at the next edge. A wake seen during the entry cycle is held and served as soon as self refresh is reached.
- R6: While `pll_ready_i`=0 the block stays in self refresh even with a pending wake. It leaves at the first edge with `pll_ready_i`=1.
- R7: Exit first runs 4 cycles with the clock on, clock-enable low and NOP. Then max(1,`cfg_cke_settle_i`) more cycles follow with clock-enable still low.
- R8: Clock-enable then rises for a NOP window of max(1,`cfg_xs_nops_i`) cycles.
- R9: Next, each rank r = 0 … K-1 in ascending order gets one cycle of command code 3 (long ZQ calibration) with only bit r of `dram_rank_sel_o` set. Each calibration is followed by `cfg_zq_gap_i` NOP cycles. K is `cfg_rank_cnt_i` clamped to the range 1 … MAX_RANKS.
- R10: One final NOP cycle with clock-enable high precedes return to normal operation. In every state other than normal operation, `sched_en_o`=0 and `txn_stall_o`=1.
- R11: `dll_off_req_o` is 1 only in the self-refresh state, only when `cfg_dll_off_en_i`=1, and never in the entry cycle.
- R12: Bits of `dram_cke_o` and `dram_rank_sel_o` for ranks at or above K are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_en_i | input | 1 | Enables idle-triggered entry |
| cfg_idle_thresh_i | input | IDLE_W | Idle cycles before automatic entry |
| cfg_cke_settle_i | input | T_W | Settling cycles between clock restart and clock-enable |
| cfg_xs_nops_i | input | T_W | NOP cycles after clock-enable rises |
| cfg_zq_gap_i | input | T_W | NOP cycles after each ZQ calibration |
| cfg_rank_cnt_i | input | RANK_CW | Number of populated ranks |
| cfg_dll_off_en_i | input | 1 | Allows a master-DLL shutdown request in self refresh |
| mc_req_i | input | 1 | Controller access or newly arriving transaction |
| mc_drained_i | input | 1 | Controller has no outstanding work |
| pwr_enter_req_i | input | 1 | Explicit entry order from the power agent |
| pwr_exit_req_i | input | 1 | Explicit wake order from the power agent |
| pll_ready_i | input | 1 | PLL locked and usable |
| dram_ck_en_o | output | 1 | DRAM clock running |
| dram_cke_o | output | MAX_RANKS | Per-rank clock-enable |
| dram_cmd_o | output | 2 | 0 none, 1 NOP, 2 self-refresh entry, 3 long ZQ calibration |
| dram_rank_sel_o | output | MAX_RANKS | Ranks addressed by `dram_cmd_o` |
| sched_en_o | output | 1 | Scheduler may issue commands |
| txn_stall_o | output | 1 | Back-pressure toward new transactions |
| dll_off_req_o | output | 1 | Master-DLL shutdown request |

## Verification
The idle threshold is probed on both sides of its boundary. This includes a threshold of zero and a count interrupted one cycle short of the threshold, so a counter that fails to restart or is off by one enters early or late.

Every cycle of the exit sequence is compared against a computed expectation for three configurations. These are zero-valued delays that must clamp to one, a rank count above the maximum, and non-zero ZQ gaps. A design that reorders ranks, miscounts a window or raises clock-enable before the settle time fails on a specific cycle.

Two further cases are tested directly:
- A wake that arrives during the entry cycle. A design that drops it stays in self refresh.
- A wake held off by a low PLL ready. A design that ignores the PLL restarts the clock too early.

// File: rtl/sref_pkg.sv
package sref_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE     = 3'd0,
      ST_SR_ENTER   = 3'd1,
      ST_IN_SR      = 3'd2,
      ST_CK_RESTART = 3'd3,
      ST_CKE_WAIT   = 3'd4,
      ST_NOP_WAIT   = 3'd5,
      ST_ZQ_ISSUE   = 3'd6,
      ST_DONE       = 3'd7
   } sref_state_e;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_NOP  = 2'd1,
      CMD_SRE  = 2'd2,
      CMD_ZQCL = 2'd3
   } sref_cmd_e;

   // clock cycles driven before any other exit step
   localparam int CK_RESTART_CYCLES = 4;

endpackage

// File: rtl/sref_idle_cnt.sv
module sref_idle_cnt #(
   parameter int IDLE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en_i,
   input  logic              busy_i,
   input  logic              auto_en_i,
   input  logic [IDLE_W-1:0] thresh_i,
   output logic              hit_o
);

   logic [IDLE_W-1:0] cnt_q;
   logic [IDLE_W-1:0] thr_m1;

   assign thr_m1 = (thresh_i == '0) ? '0 : thresh_i - IDLE_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!count_en_i || busy_i) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + IDLE_W'(1);
      end
   end

   assign hit_o = auto_en_i && count_en_i && !busy_i && (cnt_q >= thr_m1);

   // R2
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> (cnt_q == '0));

endmodule

// File: rtl/sref_dwell_timer.sv
module sref_dwell_timer #(
   parameter int T_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [T_W-1:0] load_val_i,
   output logic           zero_o
);

   logic [T_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - T_W'(1);
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sref_rank_drive.sv
module sref_rank_drive #(
   parameter int MAX_RANKS = 4,
   parameter int RANK_CW   = 3,
   parameter int RIDX_W    = 2
) (
   input  logic [RANK_CW-1:0]   rank_cnt_i,
   input  logic                 cke_on_i,
   input  logic                 drive_i,
   input  logic                 zq_sel_i,
   input  logic [RIDX_W-1:0]    zq_idx_i,
   output logic [MAX_RANKS-1:0] cke_o,
   output logic [MAX_RANKS-1:0] sel_o
);

   for (genvar r = 0; r < MAX_RANKS; r++) begin : g_rank
      logic populated;
      assign populated = (RANK_CW'(r) < rank_cnt_i);
      assign cke_o[r]  = cke_on_i && populated;
      assign sel_o[r]  = zq_sel_i ? (populated && (zq_idx_i == RIDX_W'(r)))
                                  : (drive_i && populated);
   end

endmodule

// File: rtl/dram_sref_seq.sv
module dram_sref_seq
   import sref_pkg::*;
#(
   parameter int IDLE_W       = 16,
   parameter int T_W          = 8,
   parameter int MAX_RANKS    = 4,
   parameter bit HAS_DLL_CTRL = 1'b1,
   localparam int RANK_CW     = $clog2(MAX_RANKS + 1),
   localparam int RIDX_W      = (MAX_RANKS > 1) ? $clog2(MAX_RANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_auto_en_i,
   input  logic [IDLE_W-1:0]    cfg_idle_thresh_i,
   input  logic [T_W-1:0]       cfg_cke_settle_i,
   input  logic [T_W-1:0]       cfg_xs_nops_i,
   input  logic [T_W-1:0]       cfg_zq_gap_i,
   input  logic [RANK_CW-1:0]   cfg_rank_cnt_i,
   input  logic                 cfg_dll_off_en_i,
   input  logic                 mc_req_i,
   input  logic                 mc_drained_i,
   input  logic                 pwr_enter_req_i,
   input  logic                 pwr_exit_req_i,
   input  logic                 pll_ready_i,
   output logic                 dram_ck_en_o,
   output logic [MAX_RANKS-1:0] dram_cke_o,
   output logic [1:0]           dram_cmd_o,
   output logic [MAX_RANKS-1:0] dram_rank_sel_o,
   output logic                 sched_en_o,
   output logic                 txn_stall_o,
   output logic                 dll_off_req_o
);

   // elaboration-time parameter checks
   if (MAX_RANKS < 1 || MAX_RANKS > 8) begin : g_bad_ranks
      $error("dram_sref_seq: MAX_RANKS must lie in 1..8");
   end
   if (T_W < 3) begin : g_bad_tw
      $error("dram_sref_seq: T_W must hold the clock restart count");
   end
   if (IDLE_W < 1) begin : g_bad_idle
      $error("dram_sref_seq: IDLE_W must be positive");
   end

   sref_state_e        state_q, state_d;
   logic               wake_pend_q;
   logic [RIDX_W-1:0]  zq_idx_q;
   logic               zq_gap_q;
   logic               t_load;
   logic [T_W-1:0]     t_val;
   logic               t_zero;
   logic               idle_hit;
   logic               wake_now;
   logic               enter_ok;
   logic [RANK_CW-1:0] ranks_eff;
   logic [RIDX_W-1:0]  last_idx;
   logic [T_W-1:0]     settle_m1, xs_m1, gap_m1;
   logic               cke_on, drive_all, zq_sel;
   logic [MAX_RANKS-1:0] pop_mask;

   // effective rank count clamped to 1..MAX_RANKS
   always_comb begin
      if (cfg_rank_cnt_i == '0)                          ranks_eff = RANK_CW'(1);
      else if (cfg_rank_cnt_i > RANK_CW'(MAX_RANKS))     ranks_eff = RANK_CW'(MAX_RANKS);
      else                                               ranks_eff = cfg_rank_cnt_i;
   end
   assign last_idx = RIDX_W'(ranks_eff - RANK_CW'(1));

   always_comb begin
      for (int i = 0; i < MAX_RANKS; i++) begin
         pop_mask[i] = (RANK_CW'(i) < ranks_eff);
      end
   end

   assign settle_m1 = (cfg_cke_settle_i == '0) ? '0 : cfg_cke_settle_i - T_W'(1);
   assign xs_m1     = (cfg_xs_nops_i    == '0) ? '0 : cfg_xs_nops_i    - T_W'(1);
   assign gap_m1    = (cfg_zq_gap_i     == '0) ? '0 : cfg_zq_gap_i     - T_W'(1);

   assign wake_now = pwr_exit_req_i || mc_req_i;
   assign enter_ok = pwr_enter_req_i && mc_drained_i && !mc_req_i;

   sref_idle_cnt #(.IDLE_W(IDLE_W)) idle_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .count_en_i (state_q == ST_ACTIVE),
      .busy_i     (mc_req_i || !mc_drained_i),
      .auto_en_i  (cfg_auto_en_i),
      .thresh_i   (cfg_idle_thresh_i),
      .hit_o      (idle_hit)
   );

   sref_dwell_timer #(.T_W(T_W)) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .zero_o     (t_zero)
   );

   // next-state and dwell loading
   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      unique case (state_q)
         ST_ACTIVE: begin
            if (idle_hit || enter_ok) state_d = ST_SR_ENTER;
         end
         ST_SR_ENTER: state_d = ST_IN_SR;
         ST_IN_SR: begin
            if ((wake_pend_q || wake_now) && pll_ready_i) begin
               state_d = ST_CK_RESTART;
               t_load  = 1'b1;
               t_val   = T_W'(CK_RESTART_CYCLES - 1);
            end
         end
         ST_CK_RESTART: begin
            if (t_zero) begin
               state_d = ST_CKE_WAIT;
               t_load  = 1'b1;
               t_val   = settle_m1;
            end
         end
         ST_CKE_WAIT: begin
            if (t_zero) begin
               state_d = ST_NOP_WAIT;
               t_load  = 1'b1;
               t_val   = xs_m1;
            end
         end
         ST_NOP_WAIT: begin
            if (t_zero) state_d = ST_ZQ_ISSUE;
         end
         ST_ZQ_ISSUE: begin
            if (!zq_gap_q) begin
               if (cfg_zq_gap_i == '0) begin
                  if (zq_idx_q == last_idx) state_d = ST_DONE;
               end else begin
                  t_load = 1'b1;
                  t_val  = gap_m1;
               end
            end else if (t_zero && (zq_idx_q == last_idx)) begin
               state_d = ST_DONE;
            end
         end
         ST_DONE: state_d = ST_ACTIVE;
         default: state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_ACTIVE;
      else        state_q <= state_d;
   end

   // wake held from the entry cycle until self refresh is left
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_pend_q <= 1'b0;
      end else if (state_q == ST_SR_ENTER || state_q == ST_IN_SR) begin
         if (state_d == ST_CK_RESTART) wake_pend_q <= 1'b0;
         else if (wake_now)            wake_pend_q <= 1'b1;
      end else begin
         wake_pend_q <= 1'b0;
      end
   end

   // rank walk for ZQ calibration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zq_idx_q <= '0;
         zq_gap_q <= 1'b0;
      end else if (state_q != ST_ZQ_ISSUE) begin
         zq_idx_q <= '0;
         zq_gap_q <= 1'b0;
      end else if (!zq_gap_q) begin
         if (cfg_zq_gap_i == '0) zq_idx_q <= zq_idx_q + RIDX_W'(1);
         else                    zq_gap_q <= 1'b1;
      end else if (t_zero) begin
         zq_gap_q <= 1'b0;
         zq_idx_q <= zq_idx_q + RIDX_W'(1);
      end
   end

   // output decode
   always_comb begin
      cke_on     = 1'b0;
      drive_all  = 1'b1;
      zq_sel     = 1'b0;
      dram_cmd_o = CMD_NOP;
      unique case (state_q)
         ST_ACTIVE: begin
            cke_on     = 1'b1;
            drive_all  = 1'b0;
            dram_cmd_o = CMD_NONE;
         end
         ST_SR_ENTER: dram_cmd_o = CMD_SRE;
         ST_NOP_WAIT, ST_DONE: cke_on = 1'b1;
         ST_ZQ_ISSUE: begin
            cke_on = 1'b1;
            if (!zq_gap_q) begin
               zq_sel     = 1'b1;
               dram_cmd_o = CMD_ZQCL;
            end
         end
         default: ;
      endcase
   end

   sref_rank_drive #(
      .MAX_RANKS (MAX_RANKS),
      .RANK_CW   (RANK_CW),
      .RIDX_W    (RIDX_W)
   ) rank_i (
      .rank_cnt_i (ranks_eff),
      .cke_on_i   (cke_on),
      .drive_i    (drive_all),
      .zq_sel_i   (zq_sel),
      .zq_idx_i   (zq_idx_q),
      .cke_o      (dram_cke_o),
      .sel_o      (dram_rank_sel_o)
   );

   assign dram_ck_en_o = (state_q != ST_IN_SR);
   assign sched_en_o   = (state_q == ST_ACTIVE);
   assign txn_stall_o  = (state_q != ST_ACTIVE);

   if (HAS_DLL_CTRL) begin : g_dll
      assign dll_off_req_o = cfg_dll_off_en_i && (state_q == ST_IN_SR);
   end else begin : g_no_dll
      assign dll_off_req_o = 1'b0;
   end

   // R4
   sre_then_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd_o == CMD_SRE) |=> (!dram_ck_en_o && (dram_cke_o == '0)));

   // R5
   wake_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SR_ENTER && wake_now) |=> wake_pend_q);

   // R6
   pll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IN_SR && !pll_ready_i) |=> (state_q == ST_IN_SR));

   // R7
   cke_after_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_cke_o[0]) |-> ($past(dram_ck_en_o) && $past(dram_cmd_o) == CMD_NOP));

   // R9
   zq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd_o == CMD_ZQCL) |-> ($countones(dram_rank_sel_o) == 1 && dram_cke_o[0]));

   // R10
   sched_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sched_en_o) |-> ($past(state_q) == ST_DONE));

   // R11
   dll_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dll_off_req_o |-> ($past(dram_cmd_o) == CMD_SRE || $past(dll_off_req_o)));

   // R12
   unused_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dram_cke_o | dram_rank_sel_o) & ~pop_mask) == '0);

endmodule

// File: tb/dram_sref_seq_tb_top.sv
module dram_sref_seq_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_auto_en;
   logic [15:0] cfg_idle_thresh;
   logic [7:0]  cfg_cke_settle, cfg_xs_nops, cfg_zq_gap;
   logic [2:0]  cfg_rank_cnt;
   logic        cfg_dll_off_en;
   logic        mc_req, mc_drained, pwr_enter_req, pwr_exit_req, pll_ready;
   logic        ck_en, sched_en, txn_stall, dll_off;
   logic [3:0]  cke, rank_sel;
   logic [1:0]  cmd;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_sref_seq dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .cfg_auto_en_i     (cfg_auto_en),
      .cfg_idle_thresh_i (cfg_idle_thresh),
      .cfg_cke_settle_i  (cfg_cke_settle),
      .cfg_xs_nops_i     (cfg_xs_nops),
      .cfg_zq_gap_i      (cfg_zq_gap),
      .cfg_rank_cnt_i    (cfg_rank_cnt),
      .cfg_dll_off_en_i  (cfg_dll_off_en),
      .mc_req_i          (mc_req),
      .mc_drained_i      (mc_drained),
      .pwr_enter_req_i   (pwr_enter_req),
      .pwr_exit_req_i    (pwr_exit_req),
      .pll_ready_i       (pll_ready),
      .dram_ck_en_o      (ck_en),
      .dram_cke_o        (cke),
      .dram_cmd_o        (cmd),
      .dram_rank_sel_o   (rank_sel),
      .sched_en_o        (sched_en),
      .txn_stall_o       (txn_stall),
      .dll_off_req_o     (dll_off)
   );

   typedef struct packed {
      logic [15:0] thr;
      logic [15:0] idle;
      logic        enter;
   } idle_vec_t;

   localparam idle_vec_t IDLE_VECS [6] = '{
      '{thr: 16'd5, idle: 16'd4, enter: 1'b0},
      '{thr: 16'd5, idle: 16'd5, enter: 1'b1},
      '{thr: 16'd1, idle: 16'd1, enter: 1'b1},
      '{thr: 16'd0, idle: 16'd1, enter: 1'b1},
      '{thr: 16'd3, idle: 16'd2, enter: 1'b0},
      '{thr: 16'd3, idle: 16'd3, enter: 1'b1}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [12:0] obs();
      return {sched_en, txn_stall, ck_en, cke, cmd, rank_sel};
   endfunction

   // expected {sched_en, stall, ck_en, cke, cmd, sel} k cycles after exit starts
   function automatic logic [12:0] exp_at(int k, int r, int s, int x, int g);
      int se, xe, re, zq0, done, j;
      logic [3:0] m;
      se = (s == 0) ? 1 : s;
      xe = (x == 0) ? 1 : x;
      re = (r < 1) ? 1 : ((r > 4) ? 4 : r);
      m  = 4'((1 << re) - 1);
      zq0  = 4 + se + xe;
      done = zq0 + re * (1 + g);
      if (k < 4 + se)       return {1'b0, 1'b1, 1'b1, 4'b0, 2'd1, m};
      else if (k < zq0)     return {1'b0, 1'b1, 1'b1, m, 2'd1, m};
      else if (k < done) begin
         j = k - zq0;
         if (j % (1 + g) == 0) return {1'b0, 1'b1, 1'b1, m, 2'd3, 4'(1 << (j / (1 + g)))};
         else                  return {1'b0, 1'b1, 1'b1, m, 2'd1, m};
      end
      else if (k == done)   return {1'b0, 1'b1, 1'b1, m, 2'd1, m};
      else                  return {1'b1, 1'b0, 1'b1, m, 2'd0, 4'b0};
   endfunction

   // called at the negedge where exit becomes due at the next edge
   task automatic check_seq(input int r, input int s, input int x, input int g);
      int total, k0;
      string tag;
      total = 4 + ((s == 0) ? 1 : s) + ((x == 0) ? 1 : x)
              + ((r < 1) ? 1 : ((r > 4) ? 4 : r)) * (1 + g) + 1;
      k0 = 4 + ((s == 0) ? 1 : s);
      for (int k = 0; k <= total; k++) begin
         @(negedge clk);
         if (k == 0) begin
            mc_req = 1'b0;
            pwr_exit_req = 1'b0;
         end
         if (k < k0)                                   tag = "R7 clock restart and settle";
         else if (k < k0 + ((x == 0) ? 1 : x))         tag = "R8 NOP window";
         else if (k < total - 1)                       tag = "R9 ZQ calibration per rank";
         else                                          tag = "R10 final NOP and return";
         chk(obs() == exp_at(k, r, s, x, g), tag, 32'(obs()), 32'(exp_at(k, r, s, x, g)));
      end
   endtask

   task automatic wake_to_active();
      @(negedge clk);
      pwr_exit_req = 1'b1;
      @(negedge clk);
      pwr_exit_req = 1'b0;
      for (int i = 0; i < 300 && !sched_en; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_auto_en = 1'b1;   cfg_idle_thresh = 16'd5;
      cfg_cke_settle = 8'd2; cfg_xs_nops = 8'd5; cfg_zq_gap = 8'd2;
      cfg_rank_cnt = 3'd3;  cfg_dll_off_en = 1'b1;
      mc_req = 1'b0; mc_drained = 1'b0; pwr_enter_req = 1'b0;
      pwr_exit_req = 1'b0; pll_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state (R12: rank 3 unpopulated)
      chk(obs() == {1'b1, 1'b0, 1'b1, 4'b0111, 2'd0, 4'b0000}, "R1 reset outputs",
          32'(obs()), 32'({1'b1, 1'b0, 1'b1, 4'b0111, 2'd0, 4'b0000}));
      chk(dll_off == 1'b0, "R1 dll request after reset", 32'(dll_off), 0);

      // R2 idle threshold table
      foreach (IDLE_VECS[v]) begin
         @(negedge clk);
         mc_req = 1'b1; mc_drained = 1'b0; cfg_idle_thresh = IDLE_VECS[v].thr;
         @(negedge clk);
         mc_req = 1'b0; mc_drained = 1'b1;
         repeat (int'(IDLE_VECS[v].idle)) @(negedge clk);
         mc_drained = 1'b0;
         chk(sched_en == !IDLE_VECS[v].enter, "R2 idle threshold entry",
             32'(sched_en), 32'(!IDLE_VECS[v].enter));
         if (IDLE_VECS[v].enter) begin
            chk(cmd == 2'd2 && cke == 4'b0 && ck_en && rank_sel == 4'b0111,
                "R4 entry command", 32'({cmd, cke, ck_en, rank_sel}), 32'({2'd2, 4'b0, 1'b1, 4'b0111}));
            chk(dll_off == 1'b0, "R11 no dll request in entry cycle", 32'(dll_off), 0);
            @(negedge clk);
            chk(!ck_en && cke == 4'b0 && cmd == 2'd1, "R4 self refresh state",
                32'({ck_en, cke, cmd}), 32'({1'b0, 4'b0, 2'd1}));
            chk(dll_off == 1'b1, "R11 dll request in self refresh", 32'(dll_off), 1);
            wake_to_active();
            chk(sched_en == 1'b1, "R10 back to normal after wake", 32'(sched_en), 1);
         end
      end

      // R2 interrupted count: 3 idle, 1 busy, 3 idle stays active, 4th enters
      cfg_idle_thresh = 16'd4;
      @(negedge clk); mc_req = 1'b0; mc_drained = 1'b1;
      repeat (3) @(negedge clk);
      mc_drained = 1'b0;
      @(negedge clk); mc_drained = 1'b1;
      repeat (3) @(negedge clk);
      chk(sched_en == 1'b1, "R2 count restarted after not-drained cycle", 32'(sched_en), 1);
      @(negedge clk);
      mc_drained = 1'b0;
      chk(cmd == 2'd2, "R2 entry after full restarted count", 32'(cmd), 2);
      wake_to_active();

      // R3 auto disabled; explicit entry ignored while not drained
      cfg_auto_en = 1'b0;
      @(negedge clk); mc_drained = 1'b1;
      repeat (20) @(negedge clk);
      chk(sched_en == 1'b1, "R3 no automatic entry when disabled", 32'(sched_en), 1);
      mc_drained = 1'b0; pwr_enter_req = 1'b1;
      @(negedge clk);
      pwr_enter_req = 1'b0;
      chk(sched_en == 1'b1 && cmd == 2'd0, "R3 entry order ignored when not drained",
          32'({sched_en, cmd}), 32'({1'b1, 2'd0}));
      mc_drained = 1'b1; pwr_enter_req = 1'b1;
      @(negedge clk);
      pwr_enter_req = 1'b0; mc_drained = 1'b0;
      chk(cmd == 2'd2, "R3 explicit entry order", 32'(cmd), 2);
      repeat (3) @(negedge clk);
      chk(!ck_en && txn_stall && !sched_en, "R10 stall in self refresh",
          32'({ck_en, txn_stall, sched_en}), 32'({1'b0, 1'b1, 1'b0}));
      // R5 wake by incoming transaction; full exit sequence
      mc_req = 1'b1;
      check_seq(3, 2, 5, 2);

      // R6 PLL not ready holds the wake; zero delays clamp to one, R11 dll off
      cfg_rank_cnt = 3'd1; cfg_cke_settle = 8'd0; cfg_xs_nops = 8'd0; cfg_zq_gap = 8'd0;
      cfg_dll_off_en = 1'b0;
      @(negedge clk); mc_drained = 1'b1; pwr_enter_req = 1'b1;
      @(negedge clk); pwr_enter_req = 1'b0; mc_drained = 1'b0; pll_ready = 1'b0;
      @(negedge clk);
      chk(dll_off == 1'b0, "R11 dll request disabled", 32'(dll_off), 0);
      pwr_exit_req = 1'b1;
      @(negedge clk); pwr_exit_req = 1'b0;
      repeat (5) @(negedge clk);
      chk(!ck_en && cmd == 2'd1, "R6 held in self refresh without PLL ready",
          32'({ck_en, cmd}), 32'({1'b0, 2'd1}));
      pll_ready = 1'b1;
      check_seq(1, 0, 0, 0);

      // R5 wake during entry cycle is held; rank count above maximum clamps to 4
      cfg_rank_cnt = 3'd7; cfg_cke_settle = 8'd1; cfg_xs_nops = 8'd3; cfg_zq_gap = 8'd1;
      @(negedge clk); mc_drained = 1'b1; pwr_enter_req = 1'b1;
      @(negedge clk); pwr_enter_req = 1'b0; mc_drained = 1'b0;
      pwr_exit_req = 1'b1;
      chk(cmd == 2'd2 && rank_sel == 4'b1111, "R5 wake raised in entry cycle",
          32'({cmd, rank_sel}), 32'({2'd2, 4'b1111}));
      @(negedge clk); pwr_exit_req = 1'b0;
      chk(!ck_en, "R5 self refresh reached before held wake", 32'(ck_en), 0);
      check_seq(7, 1, 3, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule